// File: doc/BRIEF.md
# Byte-Lane Predication Mask Generator

This block forms the per-byte enable mask that a 128-bit vector unit, working beat by beat, applies to one instruction. Three independent sources may disable lanes: the vector predicate (a 16-bit predicate word plus a 4-bit control field for each 8-lane half), tail predication on the last pass of a counted loop, and a code saying how many beats of the instruction already finished before an interruption. The block merges these with a default of all lanes active and registers the result, so the mask is valid one clock after its inputs.

Every output bit covers one byte lane. A consumer handling 8-bit elements reads all 16 bits. For 16-bit elements it reads bits 0, 2, 4 and so on. For 32-bit elements it reads bits 0, 4, 8 and 12. A reserved completed-beat code raises an invalid-state flag so that the surrounding pipeline can fault the instruction.

Top module: `lane_pred_mask`

## Requirements
- R1: While rst_n is low, and in the cycle after it, mask_q is 0 and invalid_q is 0.
- R2: If both half-control fields are nonzero, tail trimming is inactive and beat trimming is inactive, mask_q equals pred_bits.
- R3: If lo_ctl is zero, mask bits 7:0 are forced to 1 before trimming.
- R4: If hi_ctl is zero, mask bits 15:8 are forced to 1 before trimming.
- R5: If tail_esz is below 4 and loop_cnt is at most 16 >> tail_esz, the low (loop_cnt << tail_esz) mask bits are kept and all bits above them are cleared. A length of 16 keeps all bits, and a count of 0 clears all bits.
- R6: If tail_esz is 4 or more, or loop_cnt exceeds 16 >> tail_esz, tail trimming has no effect.
- R7: If cond_nib is 0, beat_code 1 clears bits 3:0, code 2 clears bits 7:0, and codes 4 and 5 clear bits 11:0. Code 0 clears nothing.
- R8: If cond_nib is nonzero, beat_code has no effect on the mask, and invalid_q stays 0.
- R9: If cond_nib is 0 and beat_code is 3, 6 or 7 (reserved), invalid_q is 1 and the mask is left as the predicate and tail stages produced it.
- R10: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_bits | input | 16 | Per-byte predicate word |
| lo_ctl | input | 4 | Predicate control for lanes 7:0 (0 = predication off) |
| hi_ctl | input | 4 | Predicate control for lanes 15:8 (0 = predication off) |
| tail_esz | input | 3 | Tail element-size code (log2 bytes, 4 or more = no tail) |
| loop_cnt | input | CNT_W | Remaining loop element count |
| cond_nib | input | 4 | Condition-execution nibble (beat code honoured only when 0) |
| beat_code | input | 3 | Completed-beat code |
| mask_q | output | 16 | Registered lane enable mask, 1 = active |
| invalid_q | output | 1 | Registered reserved-code flag |

## Verification
On every clock the assertions check the beat-trimming results for codes 1 and 2, the invalid flag for reserved and for masked-off codes, the forced-high upper half, the all-zero mask for a zero tail count, and the unchanged mask under a reserved code. The exact tail length for each size code, the boundary where the count equals the limit, the interaction of all three stages, and the fact that the outputs stay steady between edges can only be shown by the bench's directed and random vectors compared against its own model.

// File: rtl/lane_pred_pkg.sv
package lane_pred_pkg;

    localparam int unsigned LANES     = 16;
    localparam int unsigned NUM_BEATS = 4;
    localparam int unsigned ESZ_W     = 3;

    typedef enum logic [2:0] {
        BEAT_NONE    = 3'd0,
        BEAT_ONE     = 3'd1,
        BEAT_TWO     = 3'd2,
        BEAT_RSV3    = 3'd3,
        BEAT_THREE   = 3'd4,
        BEAT_THREE_X = 3'd5,
        BEAT_RSV6    = 3'd6,
        BEAT_RSV7    = 3'd7
    } beat_code_e;

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             invalid;
    } pred_state_t;

endpackage

// File: rtl/pred_half_merge.sv
module pred_half_merge #(
    parameter int unsigned LANES = 16,
    parameter int unsigned CTL_W = 4
) (
    input  logic [LANES-1:0] pred_bits,
    input  logic [CTL_W-1:0] lo_ctl,
    input  logic [CTL_W-1:0] hi_ctl,
    output logic [LANES-1:0] base_mask
);
    localparam int unsigned HALF = LANES / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic pred_on;
        assign pred_on = (h == 0) ? (lo_ctl != '0) : (hi_ctl != '0);
        assign base_mask[h*HALF +: HALF] =
            pred_on ? pred_bits[h*HALF +: HALF] : {HALF{1'b1}};
    end
endmodule

// File: rtl/tail_trim.sv
module tail_trim #(
    parameter int unsigned LANES = 16,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned ESZ_W = 3
) (
    input  logic [LANES-1:0] mask_in,
    input  logic [ESZ_W-1:0] esz,
    input  logic [CNT_W-1:0] cnt,
    output logic [LANES-1:0] mask_out,
    output logic             active
);
    localparam int unsigned SZ_LIM = $clog2(LANES);
    localparam int unsigned LEN_W  = SZ_LIM + 1;

    logic             esz_ok;
    logic [CNT_W-1:0] limit;
    logic [LEN_W-1:0] keep_len;

    always_comb begin
        esz_ok   = (esz < ESZ_W'(SZ_LIM));
        limit    = CNT_W'(LANES) >> esz;
        active   = esz_ok && (cnt <= limit);
        keep_len = cnt[LEN_W-1:0] << esz;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask_out[i] = mask_in[i] & (!active || (LEN_W'(i) < keep_len));
    end
endmodule

// File: rtl/beat_trim.sv
module beat_trim
    import lane_pred_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned BEATS = 4
) (
    input  logic [LANES-1:0] mask_in,
    input  logic [3:0]       cond_nib,
    input  logic [2:0]       code,
    output logic [LANES-1:0] mask_out,
    output logic             invalid
);
    localparam int unsigned BEAT_B = LANES / BEATS;
    localparam int unsigned DONE_W = $clog2(BEATS) + 1;

    logic [DONE_W-1:0] done_beats;
    logic              honoured;

    always_comb begin
        honoured   = (cond_nib == 4'd0);
        done_beats = '0;
        invalid    = 1'b0;
        if (honoured) begin
            unique case (beat_code_e'(code))
                BEAT_NONE:                done_beats = '0;
                BEAT_ONE:                 done_beats = DONE_W'(1);
                BEAT_TWO:                 done_beats = DONE_W'(2);
                BEAT_THREE, BEAT_THREE_X: done_beats = DONE_W'(3);
                default:                  invalid    = 1'b1;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned BEAT_IDX = i / BEAT_B;
        assign mask_out[i] = mask_in[i] & (DONE_W'(BEAT_IDX) >= done_beats);
    end
endmodule

// File: rtl/lane_pred_mask.sv
module lane_pred_mask
    import lane_pred_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  pred_bits,
    input  logic [3:0]        lo_ctl,
    input  logic [3:0]        hi_ctl,
    input  logic [ESZ_W-1:0]  tail_esz,
    input  logic [CNT_W-1:0]  loop_cnt,
    input  logic [3:0]        cond_nib,
    input  logic [2:0]        beat_code,
    output logic [LANES-1:0]  mask_q,
    output logic              invalid_q
);
    logic [LANES-1:0] base_mask;
    logic [LANES-1:0] tail_mask;
    logic [LANES-1:0] beat_mask;
    logic             tail_act;
    logic             beat_bad;
    pred_state_t      state_d;
    pred_state_t      state_q;

    pred_half_merge #(.LANES(LANES), .CTL_W(4)) u_merge (
        .pred_bits (pred_bits),
        .lo_ctl    (lo_ctl),
        .hi_ctl    (hi_ctl),
        .base_mask (base_mask)
    );

    tail_trim #(.LANES(LANES), .CNT_W(CNT_W), .ESZ_W(ESZ_W)) u_tail (
        .mask_in  (base_mask),
        .esz      (tail_esz),
        .cnt      (loop_cnt),
        .mask_out (tail_mask),
        .active   (tail_act)
    );

    beat_trim #(.LANES(LANES), .BEATS(NUM_BEATS)) u_beat (
        .mask_in  (tail_mask),
        .cond_nib (cond_nib),
        .code     (beat_code),
        .mask_out (beat_mask),
        .invalid  (beat_bad)
    );

    always_comb begin
        state_d         = state_q;
        state_d.mask    = beat_mask;
        state_d.invalid = beat_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_q    = state_q.mask;
    assign invalid_q = state_q.invalid;

    p_beat_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_nib == 4'd0 && beat_code == 3'd1) |=> (mask_q[3:0] == 4'h0));

    p_beat_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_nib == 4'd0 && beat_code == 3'd2) |=> (mask_q[7:0] == 8'h00));

    p_reserved_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_nib == 4'd0 && (beat_code == 3'd3 || beat_code > 3'd5)) |=> invalid_q);

    p_reserved_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_nib == 4'd0 && beat_code == 3'd3 && lo_ctl != 4'd0 && hi_ctl != 4'd0
         && tail_esz >= 3'd4) |=> (mask_q == $past(pred_bits)));

    p_cond_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_nib != 4'd0) |=> !invalid_q);

    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_esz < 3'd4 && loop_cnt == '0) |=> (mask_q == '0));

    p_hi_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_ctl == 4'd0 && cond_nib != 4'd0 && tail_esz >= 3'd4) |=> (mask_q[15:8] == 8'hFF));

endmodule

// File: tb/lane_pred_mask_tb_top.sv
`timescale 1ns/1ps
module lane_pred_mask_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      pred_bits = '0;
    logic [3:0]       lo_ctl = '0;
    logic [3:0]       hi_ctl = '0;
    logic [2:0]       tail_esz = '0;
    logic [CNT_W-1:0] loop_cnt = '0;
    logic [3:0]       cond_nib = '0;
    logic [2:0]       beat_code = '0;
    logic [15:0]      mask_q;
    logic             invalid_q;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    lane_pred_mask #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_bits(pred_bits), .lo_ctl(lo_ctl),
        .hi_ctl(hi_ctl), .tail_esz(tail_esz), .loop_cnt(loop_cnt),
        .cond_nib(cond_nib), .beat_code(beat_code),
        .mask_q(mask_q), .invalid_q(invalid_q)
    );

    function automatic logic [16:0] ref_model(logic [15:0] pb, logic [3:0] lo, logic [3:0] hi,
                                              logic [2:0] esz, logic [CNT_W-1:0] cnt,
                                              logic [3:0] cn, logic [2:0] bc);
        logic [15:0] m;
        logic        bad;
        m = pb;
        if (lo == 0) m[7:0] = 8'hFF;
        if (hi == 0) m[15:8] = 8'hFF;
        if (esz < 4 && int'(cnt) <= (16 >> esz)) begin
            int len;
            len = int'(cnt) * (1 << esz);
            for (int i = 0; i < 16; i++) if (i >= len) m[i] = 1'b0;
        end
        bad = 1'b0;
        if (cn == 0) begin
            case (bc)
                3'd0: ;
                3'd1: m = m & 16'hFFF0;
                3'd2: m = m & 16'hFF00;
                3'd4, 3'd5: m = m & 16'hF000;
                default: bad = 1'b1;
            endcase
        end
        return {bad, m};
    endfunction

    task automatic compare(string tag, logic [15:0] exp_m, logic exp_i);
        n_chk++;
        if (mask_q !== exp_m || invalid_q !== exp_i) begin
            n_bad++;
            $display("FAIL %s: mask=%h inv=%b expected mask=%h inv=%b",
                     tag, mask_q, invalid_q, exp_m, exp_i);
        end
    endtask

    task automatic vec(string tag, logic [15:0] pb, logic [3:0] lo, logic [3:0] hi,
                       logic [2:0] esz, logic [CNT_W-1:0] cnt, logic [3:0] cn, logic [2:0] bc);
        logic [16:0] e;
        @(negedge clk);
        pred_bits = pb; lo_ctl = lo; hi_ctl = hi; tail_esz = esz;
        loop_cnt = cnt; cond_nib = cn; beat_code = bc;
        e = ref_model(pb, lo, hi, esz, cnt, cn, bc);
        @(negedge clk);
        compare(tag, e[15:0], e[16]);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [15:0] prev;
        seed = $urandom(32'h5EED_1234);
        // R1 reset state
        repeat (3) @(negedge clk);
        compare("R1 in reset", 16'h0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset", 16'h0000, 1'b0);

        // R2 predicate passthrough
        vec("R2 passthrough", 16'hA5C3, 4'd8, 4'd4, 3'd7, 16'd100, 4'd1, 3'd0);
        vec("R2 passthrough b", 16'h1234, 4'd1, 4'd15, 3'd4, 16'd1, 4'd0, 3'd0);
        // R3 / R4 half forcing
        vec("R3 low half forced", 16'hA5C3, 4'd0, 4'd4, 3'd7, 16'd100, 4'd1, 3'd0);
        vec("R4 high half forced", 16'hA5C3, 4'd8, 4'd0, 3'd7, 16'd100, 4'd1, 3'd0);
        // R5 tail trimming
        vec("R5 halfword cnt 3", 16'h0000, 4'd0, 4'd0, 3'd1, 16'd3, 4'd1, 3'd0);
        vec("R5 byte cnt 16", 16'h0000, 4'd0, 4'd0, 3'd0, 16'd16, 4'd1, 3'd0);
        vec("R5 word cnt 4", 16'h0000, 4'd0, 4'd0, 3'd2, 16'd4, 4'd1, 3'd0);
        vec("R5 byte cnt 0", 16'h0000, 4'd0, 4'd0, 3'd0, 16'd0, 4'd1, 3'd0);
        vec("R5 dword cnt 1", 16'h0000, 4'd0, 4'd0, 3'd3, 16'd1, 4'd1, 3'd0);
        vec("R5 dword cnt 2", 16'h0000, 4'd0, 4'd0, 3'd3, 16'd2, 4'd1, 3'd0);
        vec("R5 byte cnt 5 pred", 16'hFF5A, 4'd2, 4'd2, 3'd0, 16'd5, 4'd1, 3'd0);
        // R6 tail inactive
        vec("R6 esz 4", 16'h0000, 4'd0, 4'd0, 3'd4, 16'd1, 4'd1, 3'd0);
        vec("R6 cnt 17", 16'h0000, 4'd0, 4'd0, 3'd0, 16'd17, 4'd1, 3'd0);
        vec("R6 word cnt 5", 16'h0000, 4'd0, 4'd0, 3'd2, 16'd5, 4'd1, 3'd0);
        // R7 beat codes
        vec("R7 code 1", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd0, 3'd1);
        vec("R7 code 2", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd0, 3'd2);
        vec("R7 code 4", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd0, 3'd4);
        vec("R7 code 5", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd0, 3'd5);
        vec("R7 code 0", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd0, 3'd0);
        // R8 beat code masked by condition nibble
        vec("R8 cond set code 2", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd4, 3'd2);
        vec("R8 cond set code 3", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd4, 3'd3);
        // R9 reserved codes
        vec("R9 code 3", 16'h3C96, 4'd1, 4'd1, 3'd7, 16'd0, 4'd0, 3'd3);
        vec("R9 code 6", 16'h3C96, 4'd1, 4'd1, 3'd1, 16'd3, 4'd0, 3'd6);
        vec("R9 code 7", 16'h0000, 4'd0, 4'd0, 3'd7, 16'd0, 4'd0, 3'd7);

        // R10 registered: output holds until the next edge
        vec("R10 setup", 16'h00F0, 4'd1, 4'd1, 3'd7, 16'd0, 4'd1, 3'd0);
        prev = mask_q;
        @(negedge clk);
        pred_bits = 16'h0F0F;
        #1;
        compare("R10 held before edge", prev, 1'b0);
        @(negedge clk);
        compare("R10 updated after edge", 16'h0F0F, 1'b0);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0]      pb;
            logic [3:0]       lo, hi, cn;
            logic [2:0]       esz, bc;
            logic [CNT_W-1:0] cnt;
            pb  = 16'($urandom);
            lo  = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
            hi  = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
            esz = 3'($urandom);
            cnt = ($urandom % 4 == 0) ? CNT_W'($urandom) : CNT_W'($urandom % 20);
            cn  = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom);
            bc  = 3'($urandom);
            vec("R10 random R5 R7 R9 mix", pb, lo, hi, esz, cnt, cn, bc);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule